// File: doc/BRIEF.md
# Evicted-Line Home/Park Steering Stage

This stage sits in the write-back path of a memory controller, between the cache eviction logic and the DRAM write queue. Each dirty line that leaves the cache arrives with its physical address and payload. The stage decides whether this node is the home of the line. It does this by comparing a node-number field in the high address bits with this node's configured number. A line whose home is this node is written to its own address in local DRAM, with the address unchanged.

A line whose home is another node is not forwarded to that node. It is parked in a reserved window of local DRAM. That window behaves like a direct-mapped store: the slot is chosen by the low bits of the line number, and the window size is set by a power-of-two line count. The window has no tags and no hit/miss logic. A parked line therefore overwrites whatever an earlier line left in the same slot, and software must deal with any collision. Every issued write carries a flag that says whether it was parked, so that a counter or software can track redirected traffic.

Both data interfaces are valid/ready. A transfer takes place on a rising edge where both valid and ready are high. A line is accepted only in a cycle where the DRAM side is ready, so the stage never holds more than one line. When the DRAM side stalls, the issued request holds every field steady until it is taken. Requests leave in the order they were accepted. Each one appears on the output one cycle after it was accepted. The configuration pins are sampled in the cycle a line is accepted, so they should only change while the path is idle.

Top module: `evict_steer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `dq_valid` is 0.
- R2: An accepted line whose address bits [NODE_LSB+NODE_W-1:NODE_LSB] (bits 39:32 by default) equal `cfg_node_id` is issued with its address unchanged and `dq_redirected` = 0.
- R3: An accepted line whose node field differs from `cfg_node_id` is issued with `dq_redirected` = 1. Its address is `cfg_region_base + ((addr >> 6) & (2^n - 1)) * 64` modulo 2^ADDR_W, where 64 is the line size in bytes and n is the effective window size code.
- R4: The window holds 2^n lines, where n = `cfg_region_log2`, clamped to MAX_LOG2 (20 by default). With n = 0, every parked line lands exactly at `cfg_region_base`.
- R5: The payload is issued bit for bit as it was accepted, on both the home path and the park path.
- R6: `wb_ready` equals `dq_ready` in every cycle, so no line is accepted while the DRAM side is stalled.
- R7: While `dq_valid` is 1 and `dq_ready` is 0, the next cycle still has `dq_valid` = 1, and the address, data and flag are unchanged.
- R8: A line accepted at a clock edge is presented on the `dq_*` outputs immediately after that edge. Lines leave in acceptance order, each exactly once, with none added.
- R9: Two parked lines that map to the same slot are both issued, to the same address, with no merge, drop or stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_node_id | input | NODE_W | Number of this node |
| cfg_region_base | input | ADDR_W | Byte address of slot 0 of the park window |
| cfg_region_log2 | input | LOG_W | Log2 of the window size in lines (clamped to MAX_LOG2) |
| wb_valid | input | 1 | Evicted line is offered |
| wb_ready | output | 1 | Stage takes the offered line this cycle |
| wb_addr | input | ADDR_W | Byte address of the evicted line |
| wb_data | input | DATA_W | Line payload |
| dq_valid | output | 1 | DRAM write request is present |
| dq_ready | input | 1 | DRAM queue takes the request this cycle |
| dq_addr | output | ADDR_W | DRAM write address |
| dq_data | output | DATA_W | DRAM write payload |
| dq_redirected | output | 1 | 1 when the write was parked in the window |

## Verification
The bench targets these corner cases:
- A window of one line, where every parked address must collapse onto the base. A design that forgot to mask would scatter these writes.
- A size code above the maximum, which must be clamped. A design that ignores the clamp widens the window past its storage.
- Two parked lines with the same slot, which both have to appear. A design that tried to merge them, or to detect a hit, would lose one.
- Stalls from the DRAM side, held for several cycles and also random. A stage that consumed input while not ready would drop or repeat lines. A stage that changed its outputs during the stall would corrupt the request in flight.
- Lines whose node field differs from this node's number by a single bit. A design that decoded the wrong field would misclassify these.

// File: rtl/evs_pkg.sv
package evs_pkg;
  typedef enum logic {
    ROUTE_HOME = 1'b0,
    ROUTE_PARK = 1'b1
  } route_e;
endpackage

// File: rtl/evs_classify.sv
module evs_classify #(
  parameter int ADDR_W   = 40,
  parameter int NODE_W   = 8,
  parameter int NODE_LSB = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NODE_W-1:0] my_node,
  output evs_pkg::route_e   route
);
  logic [NODE_W-1:0] owner;

  assign owner = addr[NODE_LSB +: NODE_W];

  always_comb begin
    route = (owner == my_node) ? evs_pkg::ROUTE_HOME : evs_pkg::ROUTE_PARK;
  end
endmodule

// File: rtl/evs_remap.sv
module evs_remap #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LOG2   = 20,
  parameter int LOG_W      = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  evs_pkg::route_e   route,
  input  logic [ADDR_W-1:0] base,
  input  logic [LOG_W-1:0]  size_log2,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W  = ADDR_W - OFFS_W;

  logic [LOG_W-1:0]  eff_log2;
  logic [IDX_W-1:0]  line_num;
  logic [IDX_W-1:0]  slot_mask;
  logic [IDX_W-1:0]  slot;
  logic [ADDR_W-1:0] park_addr;

  // clamp the window size code so it never exceeds the reserved storage
  always_comb begin
    if (int'(size_log2) > MAX_LOG2) eff_log2 = LOG_W'(MAX_LOG2);
    else                            eff_log2 = size_log2;
  end

  assign line_num  = addr[ADDR_W-1:OFFS_W];
  assign slot_mask = (IDX_W'(1) << eff_log2) - IDX_W'(1);
  assign slot      = line_num & slot_mask;
  assign park_addr = base + {slot, {OFFS_W{1'b0}}};

  always_comb begin
    out_addr = (route == evs_pkg::ROUTE_PARK) ? park_addr : addr;
  end
endmodule

// File: rtl/evs_hold_stage.sv
module evs_hold_stage #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_park,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_park
);
  // intake only when the downstream side drains this cycle: one slot, no skid
  assign in_ready = out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (out_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (out_ready && in_valid) begin
      out_addr <= in_addr;
      out_data <= in_data;
      out_park <= in_park;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_park)); // R7
endmodule

// File: rtl/evict_steer.sv
module evict_steer #(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 512,
  parameter int NODE_W     = 8,
  parameter int NODE_LSB   = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LOG2   = 20,
  parameter int LOG_W      = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] cfg_node_id,
  input  logic [ADDR_W-1:0] cfg_region_base,
  input  logic [LOG_W-1:0]  cfg_region_log2,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  output logic              dq_valid,
  input  logic              dq_ready,
  output logic [ADDR_W-1:0] dq_addr,
  output logic [DATA_W-1:0] dq_data,
  output logic              dq_redirected
);
  evs_pkg::route_e   route;
  logic [ADDR_W-1:0] steer_addr;

  evs_classify #(
    .ADDR_W(ADDR_W), .NODE_W(NODE_W), .NODE_LSB(NODE_LSB)
  ) u_class (
    .addr(wb_addr), .my_node(cfg_node_id), .route(route)
  );

  evs_remap #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_LOG2(MAX_LOG2), .LOG_W(LOG_W)
  ) u_remap (
    .addr(wb_addr), .route(route), .base(cfg_region_base),
    .size_log2(cfg_region_log2), .out_addr(steer_addr)
  );

  evs_hold_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(wb_valid), .in_ready(wb_ready),
    .in_addr(steer_addr), .in_data(wb_data),
    .in_park(route == evs_pkg::ROUTE_PARK),
    .out_valid(dq_valid), .out_ready(dq_ready),
    .out_addr(dq_addr), .out_data(dq_data), .out_park(dq_redirected)
  );

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> dq_valid); // R8
  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> dq_data == $past(wb_data)); // R5
  AST_HOME_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && (wb_addr[NODE_LSB +: NODE_W] == cfg_node_id)
    |=> !dq_redirected && dq_addr == $past(wb_addr)); // R2
  AST_FOREIGN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && (wb_addr[NODE_LSB +: NODE_W] != cfg_node_id)
    |=> dq_redirected); // R3
endmodule

// File: tb/evict_steer_tb_top.sv
module evict_steer_tb_top;
  localparam int ADDR_W = 40;
  localparam int DATA_W = 512;
  localparam int NODE_W = 8;
  localparam int LOG_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NODE_W-1:0] cfg_node_id = 8'h05;
  logic [ADDR_W-1:0] cfg_region_base = 40'h00_8000_0000;
  logic [LOG_W-1:0]  cfg_region_log2 = 5'd10;
  logic              wb_valid = 1'b0;
  logic              wb_ready;
  logic [ADDR_W-1:0] wb_addr = '0;
  logic [DATA_W-1:0] wb_data = '0;
  logic              dq_valid;
  logic              dq_ready = 1'b1;
  logic [ADDR_W-1:0] dq_addr;
  logic [DATA_W-1:0] dq_data;
  logic              dq_redirected;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;          // 0: always ready, 1: pseudo-random, 2: stalled
  logic [15:0] lfsr = 16'hACE1;
  logic [ADDR_W+DATA_W:0] exp_q[$];
  string exp_tag[$];

  evict_steer dut_i (.*);

  always #4 clk = ~clk;      // 125 MHz

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dq_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
  end

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [ADDR_W-1:0] model_addr(input logic [ADDR_W-1:0] a, output bit park);
    int n;
    logic [ADDR_W-1:0] line;
    park = (a[39:32] != cfg_node_id);
    if (!park) return a;
    n = (int'(cfg_region_log2) > 20) ? 20 : int'(cfg_region_log2);
    line = (a >> 6) & ((ADDR_W'(1) << n) - 1);
    return cfg_region_base + (line << 6);
  endfunction

  // monitor: transfer happens at the posedge after this negedge
  always @(negedge clk) begin
    if (rst_n && dq_valid && dq_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", $sformatf("unexpected write act=%h exp=none", dq_addr));
      end else begin
        logic [ADDR_W+DATA_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(dq_addr == e[ADDR_W+DATA_W:DATA_W+1], t,
              $sformatf("addr act=%h exp=%h", dq_addr, e[ADDR_W+DATA_W:DATA_W+1]));
        check(dq_redirected == e[0], t,
              $sformatf("flag act=%0d exp=%0d", dq_redirected, e[0]));
        check(dq_data == e[DATA_W:1], "R5",
              $sformatf("data act=%h exp=%h", dq_data[31:0], e[32:1]));
      end
    end
  end

  task automatic send(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
    bit park;
    logic [ADDR_W-1:0] ea;
    wb_valid = 1'b1;
    wb_addr  = a;
    wb_data  = d;
    forever begin
      if (wb_ready) begin
        ea = model_addr(a, park);
        exp_q.push_back({ea, d, park});
        exp_tag.push_back(tag);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    wb_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] rnd_data();
    logic [DATA_W-1:0] d;
    for (int k = 0; k < DATA_W / 32; k++) d[k*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    #400000;
    check(0, "WDOG", "watchdog expired act=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dq_valid == 1'b0, "R1", $sformatf("valid in reset act=%0d exp=0", dq_valid));
    rst_n = 1'b1;
    @(negedge clk);
    check(dq_valid == 1'b0, "R1", $sformatf("valid after reset act=%0d exp=0", dq_valid));

    // R2: home lines, including one whose node field is off by one bit
    send(40'h05_0000_1240, rnd_data(), "R2");
    send(40'h05_FFFF_FFC0, rnd_data(), "R2");
    send(40'h04_0000_1240, rnd_data(), "R3");
    send(40'h85_1234_5680, rnd_data(), "R3");
    drain();

    // R3/R4: different window sizes
    cfg_region_log2 = 5'd0;
    send(40'h11_ABCD_EFC0, rnd_data(), "R4");
    send(40'h22_0000_0040, rnd_data(), "R4");
    drain();
    cfg_region_log2 = 5'd31;        // clamp to 20
    send(40'h33_FFFF_FFC0, rnd_data(), "R4");
    drain();
    cfg_region_log2 = 5'd4;
    cfg_region_base = 40'hFF_FFFF_FF00; // wraps past the top
    send(40'h09_0000_03C0, rnd_data(), "R3");
    drain();

    // R9: two foreign lines with one slot
    cfg_region_base = 40'h00_4000_0000;
    cfg_region_log2 = 5'd8;
    send(40'h07_0000_4A40, rnd_data(), "R9");
    send(40'h0A_0123_0A40, rnd_data(), "R9");
    drain();

    // R6/R7: stall with a request in flight
    rdy_mode = 2;
    @(negedge clk);
    check(wb_ready == dq_ready && !wb_ready, "R6",
          $sformatf("ready under stall act=%0d exp=0", wb_ready));
    rdy_mode = 0;
    @(negedge clk);
    wb_valid = 1'b1;
    wb_addr  = 40'h06_0000_0880;
    wb_data  = rnd_data();
    begin
      bit park;
      logic [ADDR_W-1:0] ea;
      logic [ADDR_W-1:0] held;
      ea = model_addr(wb_addr, park);
      rdy_mode = 2;
      check(wb_ready == 1'b1, "R6", $sformatf("ready act=%0d exp=1", wb_ready));
      exp_q.push_back({ea, wb_data, park});
      exp_tag.push_back("R7");
      @(negedge clk);
      wb_valid = 1'b0;
      held = dq_addr;
      for (int k = 0; k < 3; k++) begin
        check(dq_valid && dq_addr == held && !dq_ready, "R7",
              $sformatf("hold act=%0d/%h exp=1/%h", dq_valid, dq_addr, held));
        @(negedge clk);
      end
      rdy_mode = 0;
    end
    drain();

    // R8: random mix under random back-pressure
    rdy_mode = 1;
    cfg_region_log2 = 5'd12;
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a;
      a = {$urandom, $urandom} & 40'hFF_FFFF_FFC0;
      if (i % 3 == 0) a[39:32] = cfg_node_id;
      send(a, rnd_data(), "R8");
      if (i % 7 == 0) @(negedge clk);
    end
    rdy_mode = 0;
    drain();
    check(exp_q.size() == 0, "R8", $sformatf("left over act=%0d exp=0", exp_q.size()));

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule